// File: doc/BRIEF.md
# Framed Serial Status Packet Receiver

This block receives the status packets that a neighbouring transmitter sends over a single wire on a clock they share. The wire is low when no packet is in flight. A packet opens with the wire high for two clocks in a row. Eight payload bits follow on consecutive clocks, most significant bit first. The packet closes with one clock on which the wire is high, and after that the wire goes low again.

The receiver passes the wire through one register stage. A small state machine then finds the opening marker, collects the payload and checks the closing marker. A good packet puts its byte on a data bus, which keeps that byte until the next good packet, and raises a one-clock valid strobe. If the closing marker is missing, the byte is thrown away and a one-clock framing-error strobe is raised instead. After any packet, good or bad, the receiver waits for the wire to be low before it looks for a new opening marker.

Top module: `statusPacketRx`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the receiver to idle and clears `rxData`, `rxValid` and `frameErr` to zero. This holds even when the reset arrives in the middle of a packet.
- R2: When idle, a packet is recognised only after `serialIn` has been high on two consecutive clocks. A single high clock followed by a low clock returns the receiver to idle and raises neither strobe.
- R3: The eight clocks after the opening marker carry the payload, most significant bit first, so the first payload bit ends up in `rxData[7]`.
- R4: If the clock after the last payload bit is high, `rxValid` is high for exactly one clock and `rxData` carries the received byte in that cycle.
- R5: If the clock after the last payload bit is low, the byte is discarded. `frameErr` is high for exactly one clock, `rxValid` stays low and `rxData` is left unchanged.
- R6: `rxData` holds its value in every cycle in which `rxValid` is low. `rxValid` and `frameErr` are never high together.
- R7: After a packet or a framing error, `serialIn` must be low for at least one clock before a new opening marker can be recognised. A wire that stays high after the closing marker starts no packet.
- R8: Packets sent back to back, with one low clock between the closing marker and the next opening marker, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the transmitter |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial status line, low when idle |
| rxData | output | 8 | Last good payload byte |
| rxValid | output | 1 | One-clock strobe for a good packet |
| frameErr | output | 1 | One-clock strobe for a missing closing marker |

## Verification
The assertions assume that `serialIn` changes only in step with `clk`, that reset is held for at least one edge at the start, and that the wire makes no demands on the receiver beyond the framing described above. The spacing check on the strobes holds only because of the framing itself: once it has reset, the receiver needs at least eleven clocks to produce any strobe. The stimulus drives the wire one bit per clock from the falling edge. It starts every packet from a low wire, except in the tests that deliberately hold the wire high or send a lone high pulse.

// File: rtl/statusPacketRxPkg.sv
package statusPacketRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SHIFT,
    ST_CLOSE,
    ST_DRAIN
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadOut;
    logic flagErr;
  } rxCtrl_t;

endpackage

// File: rtl/statusPacketRxCtrl.sv
module statusPacketRxCtrl
  import statusPacketRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    lineQ,
  output rxCtrl_t ctrl
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rxState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (lineQ) stateNext = ST_START;
      ST_START: stateNext = lineQ ? ST_SHIFT : ST_IDLE;
      ST_SHIFT: if (bitCnt == LAST_BIT) stateNext = ST_CLOSE;
      ST_CLOSE: stateNext = ST_DRAIN;
      ST_DRAIN: if (!lineQ) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SHIFT) bitCnt <= bitCnt + 1'b1;
      else                   bitCnt <= '0;
    end
  end

  always_comb begin
    ctrl.shiftEn = (state == ST_SHIFT);
    ctrl.loadOut = (state == ST_CLOSE) &&  lineQ;
    ctrl.flagErr = (state == ST_CLOSE) && !lineQ;
  end

endmodule

// File: rtl/statusPacketRxPath.sv
module statusPacketRxPath
  import statusPacketRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  rxCtrl_t           ctrl,
  output logic              lineQ,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              frameErr
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineQ    <= 1'b0;
      shiftReg <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      lineQ    <= serialIn;
      rxValid  <= ctrl.loadOut;
      frameErr <= ctrl.flagErr;
      if (ctrl.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], lineQ};
      if (ctrl.loadOut) rxData   <= shiftReg;
    end
  end

endmodule

// File: rtl/statusPacketRx.sv
module statusPacketRx
  import statusPacketRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              frameErr
);

  rxCtrl_t ctrl;
  logic    lineQ;

  statusPacketRxCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .lineQ (lineQ),
    .ctrl  (ctrl)
  );

  statusPacketRxPath #(.DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .ctrl     (ctrl),
    .lineQ    (lineQ),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .frameErr (frameErr)
  );

endmodule

// File: rtl/statusPacketRxChk.sv
module statusPacketRxChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              serialIn,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              frameErr
);

  logic [7:0] gapCnt;
  logic       strobe;

  assign strobe = rxValid || frameErr;

  always_ff @(posedge clk) begin
    if (rst)                 gapCnt <= '0;
    else if (strobe)         gapCnt <= '0;
    else if (gapCnt != 8'hFF) gapCnt <= gapCnt + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rxValid && !frameErr && rxData == '0)); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> !frameErr); // R5

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rxValid && frameErr)); // R6

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rxValid && !$past(rst)) |-> $stable(rxData)); // R6

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (gapCnt >= 8'(DATA_W))); // R2

endmodule

bind statusPacketRx statusPacketRxChk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .rxData   (rxData),
  .rxValid  (rxValid),
  .frameErr (frameErr)
);

// File: tb/tb_statusPacketRx.sv
module tb_statusPacketRx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       frameErr;

  int checks = 0;
  int failures = 0;
  logic [7:0] lastGood = 8'h00;

  typedef struct {
    logic       isErr;
    logic [7:0] data;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  statusPacketRx dut (
    .clk(clk), .rst(rst), .serialIn(serialIn),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serialIn = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic sendPacket(input logic [7:0] d, input logic closeBit, input string req);
    expItem_t it;
    sendBit(1'b1);
    sendBit(1'b1);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    it.isErr = !closeBit;
    it.data  = closeBit ? d : lastGood;
    it.req   = req;
    if (closeBit) lastGood = d;
    expQ.push_back(it);
    sendBit(closeBit);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (rxValid || frameErr)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected strobe", {rxValid, frameErr}, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(!(rxValid && frameErr), "R6", "both strobes", 3, 1);
        check(frameErr == e.isErr, e.req, "strobe kind (err)", frameErr, e.isErr);
        check(rxData == e.data, e.req, "rxData", rxData, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(rxData == 8'h00 && !rxValid && !frameErr, "R1", "reset outputs",
          {rxData, rxValid, frameErr}, 0);
    idle(3);
    // R3/R4: basic packets, varied patterns
    sendPacket(8'hA5, 1'b1, "R3"); idle(3);
    sendPacket(8'h80, 1'b1, "R3"); idle(2);
    sendPacket(8'h01, 1'b1, "R4"); idle(2);
    sendPacket(8'hFF, 1'b1, "R4"); idle(2);
    sendPacket(8'h00, 1'b1, "R4"); idle(4);
    // R2: single high glitch, no strobe expected
    sendBit(1'b1); idle(6);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); idle(5);
    sendPacket(8'h3C, 1'b1, "R2"); idle(3);
    // R5/R6: missing closing marker, data holds previous byte
    sendPacket(8'h77, 1'b0, "R5"); idle(4);
    check(rxData == 8'h3C, "R6", "rxData after error", rxData, 8'h3C);
    sendPacket(8'h5A, 1'b1, "R5"); idle(3);
    // R7: line stays high after closing marker
    sendPacket(8'hC3, 1'b1, "R7");
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    idle(3);
    sendPacket(8'h96, 1'b1, "R7"); idle(2);
    // R8: back-to-back with one low clock
    sendPacket(8'h12, 1'b1, "R8"); idle(1);
    sendPacket(8'hED, 1'b1, "R8"); idle(1);
    sendPacket(8'h6B, 1'b0, "R8"); idle(1);
    sendPacket(8'h4F, 1'b1, "R8"); idle(4);
    // R1: reset in mid-packet
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rxData == 8'h00 && !rxValid && !frameErr, "R1", "mid-packet reset",
          {rxData, rxValid, frameErr}, 0);
    serialIn = 1'b0;
    rst = 1'b0;
    lastGood = 8'h00;
    idle(2);
    sendPacket(8'hB4, 1'b1, "R1"); idle(6);
    check(expQ.size() == 0, "R4", "pending expected items", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule